// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks. Each side has a strobe pair: an enable and a chip select. A word moves only when both are high. The storage holds 2^AW words of DW bits.

The write side raises a full flag and an almost-full flag. The read side raises an empty flag and an almost-empty flag. All three thresholds are inputs and may be changed between uses: the full level, the almost-full level and the almost-empty level. Each flag is a register in its own clock domain. Pointers pass between the domains in Gray code through a two-stage synchroniser, so a flag that depends on the far side clears a few cycles late but is never optimistic.

A shared synchronous reset, held across several edges of both clocks, empties the buffer. A separate rewind input, on the read clock, returns only the read pointer to the first location. The consumer can then replay everything written since the last reset.

Top module: `afifo_pf`

## Requirements
- R1: While and after `rst`, `empty` and `aempty` read 1, `full` and `afull` read 0, and `rdata` reads 0.
- R2: Words leave in the order they were accepted, unchanged, including across pointer wrap-around.
- R3: A write presented while `full` is 1 is dropped. The write pointer does not move and the word is never read out.
- R4: A read presented while `empty` is 1 is dropped. The read pointer does not move and `rdata` keeps its value.
- R5: A write is accepted only when `wce` and `we` are both 1. A read is accepted only when `rce` and `re` are both 1. A single strobe alone changes neither the fill level nor `rdata`.
- R6: `full` is a write-clock register equal to (level ≥ `full_lvl`), with `full_lvl` in 1..2^AW−1. It reflects an accepted write at the same write-clock edge.
- R7: `afull` is a write-clock register equal to (level ≥ `afull_lvl`), with `afull_lvl` in 1..`full_lvl`−1.
- R8: `empty` is a read-clock register equal to (level = 0). `aempty` is a read-clock register equal to (level ≤ `aempty_lvl`), with `aempty_lvl` in 1..`full_lvl`−1. Once the pointers have settled, both agree with the true level.
- R9: A one-cycle pulse on `rewind` puts the read pointer back at location 0. The reads that follow return the words accepted since the last `rst`, oldest first. `rewind` takes priority over a read in the same cycle.
- R10: `rdata` takes the word at the read pointer at the read-clock edge that accepts a read. It holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | write-side clock |
| rclk | input | 1 | read-side clock |
| rst | input | 1 | synchronous active-high clear of the whole FIFO, held over both clocks |
| rewind | input | 1 | read-clock pulse that returns the read pointer to location 0 |
| wce | input | 1 | write chip enable |
| we | input | 1 | write enable |
| wdata | input | DW | word to store |
| rce | input | 1 | read chip enable |
| re | input | 1 | read enable |
| rdata | output | DW | registered read word |
| full_lvl | input | AW | level at which `full` rises |
| afull_lvl | input | AW | level at which `afull` rises |
| aempty_lvl | input | AW | level at or below which `aempty` is high |
| full | output | 1 | write-domain full flag |
| afull | output | 1 | write-domain almost-full flag |
| empty | output | 1 | read-domain empty flag |
| aempty | output | 1 | read-domain almost-empty flag |

## Verification
Pushes and pops landing in the same stretch of time are the interesting collision. Each side reaches its flags only through the other side's delayed pointer copy. The bench runs a writer and a reader in parallel, on clocks of different periods, over more than two trips around the storage. It judges each popped word against a queue filled by the writer. The fill sweep also presents writes at the full boundary, and the rewind test lets a rewind pulse land while the read side has already consumed part of the data. Ordering, flag state after settling, and the replayed words are all compared with the bench's own model.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic full;
        logic afull;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic aempty;
    } rd_flags_t;

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = afifo_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl #(
    parameter int AW = 4,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wce,
    input  logic          we,
    input  logic [AW-1:0] full_lvl,
    input  logic [AW-1:0] afull_lvl,
    input  logic [PW-1:0] rgray_sync,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          wen,
    output afifo_pkg::wr_flags_t flags
);
    logic [PW-1:0] wbin, wbin_n, rbin, lvl_n;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_sync >> i);
    end

    assign wen    = wce && we && !flags.full;
    assign wbin_n = wbin + PW'(wen);
    assign lvl_n  = wbin_n - rbin;
    assign waddr  = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
            flags <= '{full: 1'b0, afull: 1'b0};
        end else begin
            wbin        <= wbin_n;
            wgray       <= wbin_n ^ (wbin_n >> 1);
            flags.full  <= lvl_n >= {1'b0, full_lvl};
            flags.afull <= lvl_n >= {1'b0, afull_lvl};
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (flags.full && wce && we) |=> $stable(wgray)); // R3
    AST_FULL_HAS_AFULL: assert property (@(posedge clk) disable iff (rst)
        flags.full |-> flags.afull); // R7
    AST_WGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1); // R2
endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl #(
    parameter int AW = 4,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rewind,
    input  logic          rce,
    input  logic          re,
    input  logic [AW-1:0] aempty_lvl,
    input  logic [PW-1:0] wgray_sync,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic          ren,
    output afifo_pkg::rd_flags_t flags
);
    logic [PW-1:0] rbin, rbin_n, wbin, lvl_n;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_sync >> i);
    end

    assign ren    = rce && re && !flags.empty && !rewind;
    assign rbin_n = rewind ? '0 : rbin + PW'(ren);
    assign lvl_n  = wbin - rbin_n;
    assign raddr  = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            flags <= '{empty: 1'b1, aempty: 1'b1};
        end else begin
            rbin         <= rbin_n;
            rgray        <= rbin_n ^ (rbin_n >> 1);
            flags.empty  <= lvl_n == '0;
            flags.aempty <= lvl_n <= {1'b0, aempty_lvl};
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && rce && re && !rewind) |=> $stable(rgray)); // R4
    AST_EMPTY_HAS_AEMPTY: assert property (@(posedge clk) disable iff (rst)
        flags.empty |-> flags.aempty); // R8
    AST_REWIND_HOME: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (rgray == '0)); // R9
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
    parameter int DW = 8,
    parameter int AW = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          ren,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (wen) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst)     rdata <= '0;
        else if (ren) rdata <= store[raddr];
    end

    AST_RDATA_HOLD: assert property (@(posedge rclk) disable iff (rrst)
        !ren |=> $stable(rdata)); // R10
endmodule

// File: rtl/afifo_pf.sv
module afifo_pf #(
    parameter int DW = 8,
    parameter int AW = 4,
    localparam int PW = AW + 1
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          rewind,
    input  logic          wce,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          rce,
    input  logic          re,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] full_lvl,
    input  logic [AW-1:0] afull_lvl,
    input  logic [AW-1:0] aempty_lvl,
    output logic          full,
    output logic          afull,
    output logic          empty,
    output logic          aempty
);
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic          wen, ren;
    afifo_pkg::wr_flags_t wfl;
    afifo_pkg::rd_flags_t rfl;

    afifo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));
    afifo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));

    afifo_wr_ctl #(.AW(AW)) u_wr (
        .clk(wclk), .rst(rst), .wce(wce), .we(we),
        .full_lvl(full_lvl), .afull_lvl(afull_lvl),
        .rgray_sync(rgray_s), .wgray(wgray), .waddr(waddr), .wen(wen), .flags(wfl)
    );

    afifo_rd_ctl #(.AW(AW)) u_rd (
        .clk(rclk), .rst(rst), .rewind(rewind), .rce(rce), .re(re),
        .aempty_lvl(aempty_lvl), .wgray_sync(wgray_s),
        .rgray(rgray), .raddr(raddr), .ren(ren), .flags(rfl)
    );

    afifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wclk), .rclk(rclk), .rrst(rst),
        .wen(wen), .waddr(waddr), .wdata(wdata),
        .ren(ren), .raddr(raddr), .rdata(rdata)
    );

    assign full   = wfl.full;
    assign afull  = wfl.afull;
    assign empty  = rfl.empty;
    assign aempty = rfl.aempty;
endmodule

// File: tb/afifo_pf_test.sv
module afifo_pf_test;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int FULL_L = 12, AFULL_L = 10, AEMPTY_L = 3;

    logic wclk = 0, rclk = 0, rst = 1, rewind = 0;
    logic wce = 0, we = 0, rce = 0, re = 0;
    logic [DW-1:0] wdata = '0, rdata;
    logic [AW-1:0] full_lvl = AW'(FULL_L), afull_lvl = AW'(AFULL_L), aempty_lvl = AW'(AEMPTY_L);
    logic full, afull, empty, aempty;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [DW-1:0] sb[$];
    logic [DW-1:0] hist[$];

    always #(WCLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    afifo_pf #(.DW(DW), .AW(AW)) uut (
        .wclk(wclk), .rclk(rclk), .rst(rst), .rewind(rewind),
        .wce(wce), .we(we), .wdata(wdata), .rce(rce), .re(re), .rdata(rdata),
        .full_lvl(full_lvl), .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl),
        .full(full), .afull(afull), .empty(empty), .aempty(aempty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        @(negedge wclk); rst = 0;
        sb.delete(); hist.delete();
    endtask

    task automatic settle();
        repeat (5) @(negedge wclk);
        repeat (5) @(negedge rclk);
    endtask

    // driver: pushes accepted words into the scoreboard
    task automatic wr(input logic [DW-1:0] d, input bit c, input bit e);
        bit acc;
        @(negedge wclk);
        acc = c && e && !full;
        wce = c; we = e; wdata = d;
        @(negedge wclk);
        wce = 0; we = 0;
        if (acc) begin sb.push_back(d); hist.push_back(d); end
    endtask

    // monitor: pops and compares at the edge after an accepted read
    task automatic rd(input bit c, input bit e, output bit acc);
        logic [DW-1:0] old, exp;
        @(negedge rclk);
        acc = c && e && !empty;
        old = rdata;
        rce = c; re = e;
        @(negedge rclk);
        rce = 0; re = 0;
        if (acc) begin
            exp = sb.pop_front();
            check(rdata === exp, "R2 order", int'(rdata), int'(exp));
        end else begin
            check(rdata === old, "R4/R5/R10 hold", int'(rdata), int'(old));
        end
    endtask

    task automatic chk_flags(input int lvl, input string tag);
        check(full   === (lvl >= FULL_L),   {tag, " R6 full"},   int'(full),   int'(lvl >= FULL_L));
        check(afull  === (lvl >= AFULL_L),  {tag, " R7 afull"},  int'(afull),  int'(lvl >= AFULL_L));
        check(empty  === (lvl == 0),        {tag, " R8 empty"},  int'(empty),  int'(lvl == 0));
        check(aempty === (lvl <= AEMPTY_L), {tag, " R8 aempty"}, int'(aempty), int'(lvl <= AEMPTY_L));
    endtask

    initial begin
        bit acc;
        int got;
        do_reset();
        // R1 reset state
        check(empty === 1 && aempty === 1, "R1 read flags", int'({empty, aempty}), 3);
        check(full === 0 && afull === 0, "R1 write flags", int'({full, afull}), 0);
        check(rdata === '0, "R1 rdata", int'(rdata), 0);

        // R6/R7: fill past threshold; write flags react at the same write edge
        for (int i = 0; i < 14; i++) begin
            wr(DW'(8'h40 + i), 1, 1);
            check(full === (sb.size() >= FULL_L), "R6 full now", int'(full), int'(sb.size() >= FULL_L));
            check(afull === (sb.size() >= AFULL_L), "R7 afull now", int'(afull), int'(sb.size() >= AFULL_L));
        end
        // R3: the two writes while full were dropped
        check(sb.size() == FULL_L, "R3 level", sb.size(), FULL_L);
        settle();
        chk_flags(sb.size(), "full");

        // R5: single read strobe does nothing
        rd(1, 0, acc);
        rd(0, 1, acc);
        settle();
        chk_flags(sb.size(), "R5 rd strobe");

        // drain with flag sampling
        while (sb.size() > 0) begin
            rd(1, 1, acc);
            settle();
            chk_flags(sb.size(), "drain");
        end
        // R4: read on empty keeps rdata
        rd(1, 1, acc);
        check(acc == 0, "R4 no accept", int'(acc), 0);

        // R5: single write strobe does nothing
        wr(8'hEE, 0, 1);
        wr(8'hEF, 1, 0);
        settle();
        chk_flags(0, "R5 wr strobe");

        // R9: rewind replays since reset
        do_reset();
        for (int i = 0; i < 6; i++) wr(DW'(8'hA0 + i), 1, 1);
        settle();
        for (int i = 0; i < 4; i++) rd(1, 1, acc);
        @(negedge rclk); rewind = 1; rce = 1; re = 1;
        @(negedge rclk); rewind = 0; rce = 0; re = 0;
        sb = hist;
        settle();
        chk_flags(6, "R9 after rewind");
        for (int i = 0; i < 6; i++) begin
            rd(1, 1, acc);
            check(acc == 1, "R9 replay accept", int'(acc), 1);
        end

        // R2: concurrent streaming across wrap
        do_reset();
        got = 0;
        fork
            for (int i = 0; i < 40; i++) begin
                wr(DW'(i * 7 + 3), 1, 1);
                while (hist.size() <= i) wr(DW'(i * 7 + 3), 1, 1);
            end
            while (got < 40) begin
                rd(1, 1, acc);
                if (acc) got++;
            end
        join
        check(got == 40, "R2 stream count", got, 40);
        settle();
        chk_flags(0, "R2 end");
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge wclk);
            cyc++;
        end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule